// File: doc/BRIEF.md
# Trigger and Busy Control Unit

This block decides when a new event may start. It takes trigger requests from two sources. One is the rising edge of an external trigger line. The other is an internal periodic generator whose period is given in 320 ns time units. A free-running prescaler divides the system clock down to one tick every 320 ns. A request is turned into an accepted trigger only while acquisition is running and the general busy flag is low. Each accepted trigger is a one-cycle pulse. It carries a calibration tag when calibration mode is selected.

The general busy flag is formed from sixteen busy sources. Eight of them only count when all eight are high together. Any one of the other eight is enough on its own. Busy is also raised by the block's own event state. It stays high from an accepted trigger until the event-done input arrives. After that it stays high for a programmable number of 320 ns ticks.

Separate counters are kept for external and internal trigger requests. A saturating counter records the requests that came in while busy was high. A clear input resets all the counters at once.

Top module: `trig_busy_ctrl`

## Requirements
- R1: With the internal trigger enabled and acquisition running, internal requests repeat every `int_period` ticks, which is `int_period` × TICK_DIV clock cycles. A period of 0 behaves as a period of 1.
- R2: With `int_trig_en` low, no internal request occurs, `int_count` does not change and no trigger is produced.
- R3: Only a low-to-high transition of `ext_trig` is an external request. A level held high yields a single request.
- R4: A request is accepted only when `run` is high and `busy` is low. `trig_out` is then high for exactly the one cycle after the clock edge that sampled the request.
- R5: `trig_calib` is high together with `trig_out` when `calib_mode` was high at acceptance. Otherwise it is low.
- R6: `busy` is high when all bits of `and_busy` are 1, or when any bit of `or_busy` is 1. Both groups give no busy out of reset.
- R7: After an accepted trigger, `busy` stays high until `event_done` is sampled high. It then stays high for exactly `busy_ext` further ticks. When `busy_ext` is 0, `busy` falls right after the `event_done` edge.
- R8: While `run` is high, every external request increments `ext_count` and every internal request increments `int_count`, whether or not it is accepted.
- R9: Requests that arrive while `run` and `busy` are both high increment `busy_trig_count`. This counter saturates at 255.
- R10: `clr_counts` sampled high sets `ext_count`, `int_count` and `busy_trig_count` to 0 on the next edge.
- R11: While `run` is low, no trigger is accepted and no counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Acquisition running (start/stop) |
| clr_counts | input | 1 | Synchronous clear of all counters |
| int_trig_en | input | 1 | Internal periodic trigger enable |
| calib_mode | input | 1 | Tag accepted triggers as calibration |
| int_period | input | 28 | Internal trigger period in 320 ns ticks |
| busy_ext | input | 16 | Busy extension after event end, in ticks |
| ext_trig | input | 1 | External trigger line |
| and_busy | input | 8 | Busy sources that count only when all are high |
| or_busy | input | 8 | Busy sources that each assert busy alone |
| event_done | input | 1 | End of the current event |
| trig_out | output | 1 | Accepted trigger pulse |
| trig_calib | output | 1 | Calibration tag for the accepted trigger |
| busy | output | 1 | General busy flag |
| ext_count | output | 32 | External trigger request count |
| int_count | output | 32 | Internal trigger request count |
| busy_trig_count | output | 8 | Saturating count of requests seen while busy |

## Verification
The timing of each result follows from the number of registers it passes through.
- `trig_out`, `trig_calib`, the counters and the event part of `busy` change on the first edge that samples a request. The bench drives stimulus on a falling edge and checks these on the next falling edge.
- The group part of `busy` is combinational, so it is checked a moment after the inputs change.
- The busy extension ends exactly `busy_ext` ticks after the `event_done` edge. With the bench's divider of 4, busy is checked still high 8 edges after that edge and low at 12 edges, for an extension of 3 ticks.
- The internal period is measured as the number of cycles between successive `trig_out` pulses.

// File: rtl/trig_busy_ctrl.sv
module trig_busy_ctrl #(
  parameter int TICK_DIV = 64,
  parameter int PER_W    = 28,
  parameter int EXT_W    = 16,
  parameter int NGRP     = 8,
  parameter int CNT_W    = 32,
  parameter int BT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr_counts,
  input  logic             int_trig_en,
  input  logic             calib_mode,
  input  logic [PER_W-1:0] int_period,
  input  logic [EXT_W-1:0] busy_ext,
  input  logic             ext_trig,
  input  logic [NGRP-1:0]  and_busy,
  input  logic [NGRP-1:0]  or_busy,
  input  logic             event_done,
  output logic             trig_out,
  output logic             trig_calib,
  output logic             busy,
  output logic [CNT_W-1:0] ext_count,
  output logic [CNT_W-1:0] int_count,
  output logic [BT_W-1:0]  busy_trig_count
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [BT_W-1:0]  BT_MAX = '1;

  logic [DIV_W-1:0] div_q;
  logic [PER_W-1:0] per_q;
  logic [EXT_W-1:0] ext_left;
  logic             ext_q, evt_q;

  wire tick      = (div_q == DIV_LAST);
  wire int_on    = int_trig_en && run;
  wire [PER_W-1:0] per_last = (int_period == '0) ? '0 : int_period - 1'b1;
  wire int_req   = int_on && tick && (per_q >= per_last);
  wire ext_req   = ext_trig && !ext_q;
  wire any_req   = ext_req || int_req;
  wire grp_busy  = (&and_busy) || (|or_busy);
  assign busy    = grp_busy || evt_q || (ext_left != '0);
  wire accept    = run && !busy && any_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       per_q <= '0;
    else if (!int_on) per_q <= '0;
    else if (tick)    per_q <= (per_q >= per_last) ? '0 : per_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_q    <= 1'b0;
      ext_left <= '0;
    end else begin
      if (accept)          evt_q <= 1'b1;
      else if (event_done) evt_q <= 1'b0;
      if (evt_q && event_done && !accept) ext_left <= busy_ext;
      else if (tick && ext_left != '0)    ext_left <= ext_left - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trig_out   <= 1'b0;
      trig_calib <= 1'b0;
    end else begin
      trig_out   <= accept;
      trig_calib <= accept && calib_mode;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_count       <= '0;
      int_count       <= '0;
      busy_trig_count <= '0;
    end else if (clr_counts) begin
      ext_count       <= '0;
      int_count       <= '0;
      busy_trig_count <= '0;
    end else begin
      if (run && ext_req) ext_count <= ext_count + 1'b1;
      if (int_req)        int_count <= int_count + 1'b1;
      if (run && busy && any_req && busy_trig_count != BT_MAX)
        busy_trig_count <= busy_trig_count + 1'b1;
    end

  assert_accept_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(run && !busy));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);
  assert_event_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> busy);
  assert_calib_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_calib |-> trig_out);
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_trig_count == BT_MAX && !clr_counts) |=> busy_trig_count == BT_MAX);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_counts |=> (ext_count == '0 && int_count == '0 && busy_trig_count == '0));
  assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !trig_out);
endmodule

// File: tb/tb_trig_busy_ctrl.sv
module tb_trig_busy_ctrl;
  localparam int TICK = 4;
  logic clk = 0, rst_n = 0;
  logic run = 0, clr_counts = 0, int_trig_en = 0, calib_mode = 0;
  logic [27:0] int_period = 28'd5;
  logic [15:0] busy_ext = 16'd0;
  logic ext_trig = 0, event_done = 0;
  logic [7:0] and_busy = 0, or_busy = 0;
  logic trig_out, trig_calib, busy;
  logic [31:0] ext_count, int_count;
  logic [7:0] busy_trig_count;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  trig_busy_ctrl #(.TICK_DIV(TICK)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ext();
    ext_trig = 1; step(1); ext_trig = 0; step(1);
  endtask

  task automatic finish_event();
    event_done = 1; step(1); event_done = 0;
  endtask

  task automatic t_reset();
    check("R6 reset busy", busy, 0);
    check("R4 reset trig", trig_out, 0);
    check("R10 reset counts", ext_count | int_count | busy_trig_count, 0);
  endtask

  task automatic t_ext_accept();
    logic [31:0] e0;
    run = 1; e0 = ext_count;
    ext_trig = 1; step(1);
    check("R4 trig_out after edge", trig_out, 1);
    check("R7 busy after accept", busy, 1);
    check("R8 ext_count", ext_count, e0 + 1);
    step(1);
    check("R3 held level single pulse", trig_out, 0);
    check("R3 held level count", ext_count, e0 + 1);
    ext_trig = 0; step(1);
    finish_event();
    check("R7 zero extension clears", busy, 0);
  endtask

  task automatic t_busy_reject();
    logic [31:0] e0;
    ext_trig = 1; step(1); ext_trig = 0; step(1);
    e0 = ext_count;
    ext_trig = 1; step(1);
    check("R4 rejected while busy", trig_out, 0);
    check("R9 busy trigger counted", busy_trig_count, 1);
    check("R8 ext counted while busy", ext_count, e0 + 1);
    ext_trig = 0; step(1);
    finish_event();
  endtask

  task automatic t_groups();
    and_busy = 8'hFE; #1 check("R6 partial and group", busy, 0);
    and_busy = 8'hFF; #1 check("R6 full and group", busy, 1);
    and_busy = 8'h00; or_busy = 8'h10; #1 check("R6 or group", busy, 1);
    or_busy = 8'h00; #1 check("R6 groups idle", busy, 0);
    step(1);
  endtask

  task automatic t_extension();
    busy_ext = 16'd3;
    pulse_ext();
    finish_event();
    step(7);
    check("R7 extension still busy", busy, 1);
    step(4);
    check("R7 extension ended", busy, 0);
    busy_ext = 0;
  endtask

  task automatic t_calib();
    calib_mode = 1; ext_trig = 1; step(1);
    check("R5 calib tag set", trig_calib, 1);
    ext_trig = 0; step(1); finish_event();
    calib_mode = 0; ext_trig = 1; step(1);
    check("R5 calib tag clear", {trig_out, trig_calib}, 2'b10);
    ext_trig = 0; step(1); finish_event();
  endtask

  task automatic t_internal();
    int t = 0, t1 = 0, pulses = 0;
    logic [31:0] i0;
    event_done = 1; int_period = 28'd5; int_trig_en = 1;
    while (!trig_out && t < 200) begin step(1); t++; end
    i0 = int_count; t = 0;
    step(1);
    while (!trig_out && t < 200) begin step(1); t++; end
    t1 = t + 1;
    check("R1 internal period cycles", t1, 5 * TICK);
    check("R8 int_count", int_count, i0 + 1);
    int_trig_en = 0; step(1); i0 = int_count;
    for (int k = 0; k < 100; k++) begin step(1); if (trig_out) pulses++; end
    check("R2 disabled no trigger", pulses, 0);
    check("R2 disabled count stable", int_count, i0);
    event_done = 0;
  endtask

  task automatic t_stop();
    logic [31:0] e0;
    run = 0; e0 = ext_count;
    ext_trig = 1; step(1);
    check("R11 no trigger when stopped", trig_out, 0);
    check("R11 no count when stopped", ext_count, e0);
    ext_trig = 0; step(1); run = 1;
  endtask

  task automatic t_saturate();
    or_busy = 8'h01;
    for (int k = 0; k < 300; k++) pulse_ext();
    check("R9 saturates at 255", busy_trig_count, 255);
    or_busy = 0;
  endtask

  task automatic t_clear();
    clr_counts = 1; step(1); clr_counts = 0;
    check("R10 clear", ext_count | int_count | busy_trig_count, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(3); rst_n = 1; step(1);
    t_reset();
    t_ext_accept();
    t_busy_reject();
    t_groups();
    t_extension();
    t_calib();
    t_internal();
    t_stop();
    t_saturate();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule